// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from twelve external lines and four on-chip lines and delivers them to two processor cores. Each of the sixteen sources carries its own configuration word: an 8-bit vector, a 4-bit priority, a mask bit, a trigger mode (level or edge) and a two-bit core route. Each core has a task-priority threshold and an in-service record, and gets one interrupt line, one acknowledge strobe, one end-of-interrupt strobe and one vector output.

Delivery is fully nested. A source reaches a core only when its priority is strictly above both the core's threshold and the highest priority that core already has in service. So a more urgent source pre-empts a handler that is running, and equal or lower ones wait. On an acknowledge, the core reads the vector of the best eligible source in the same cycle. At the next edge, that source's priority is recorded as in service and any edge-latched request is cleared. An acknowledge with nothing eligible returns the spurious vector 0xFF. An end-of-interrupt retires the highest in-service priority.

Each core's output comes from a two-state machine, `CORE_QUIET` and `CORE_RAISED`. The machine moves QUIET→RAISED when some source is eligible for that core, and RAISED→QUIET when none is. Otherwise it stays where it is. A global reset write sends every machine to `CORE_QUIET`.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every source reads back 0x1000: masked, priority 0, vector 0, level-triggered, routed nowhere. Both thresholds read 0, both in-service records are empty and both core_irq bits are 0.
- R2: Source i's configuration sits at address 0x10+i. The fields are: bits [7:0] vector, bits [11:8] priority, bit 12 mask (1 blocks delivery), bit 13 trigger (1 edge, 0 level), bit 14 route to core 0 and bit 15 route to core 1. A read returns the stored bits with bits 31:16 as 0. Sources 0–11 are irq_ext[0..11] and sources 12–15 are irq_int[0..3].
- R3: Core c's task-priority threshold sits at address 0x04+c, in bits [3:0]. A source is eligible for core c only when its priority is strictly greater than this threshold.
- R4: core_irq[c] is 1 in the cycle after one in which some source was eligible for core c, and 0 in the cycle after one in which none was.
- R5: While core_ack[c] is 1, core_vec[8c+7:8c] shows the vector of the eligible source with the highest priority. On a tie the lowest source index wins. At the clock edge that priority joins core c's in-service record.
- R6: A source is eligible for core c only when its priority is strictly above the highest priority in core c's in-service record. A higher-priority source is therefore delivered while a lower one is in service.
- R7: A core_eoi[c] pulse removes the highest priority from core c's in-service record. Lower entries stay in place.
- R8: An acknowledge when nothing is eligible returns vector 0xFF and leaves the in-service record unchanged.
- R9: An edge-triggered source latches a pending request on a 0→1 input transition, even while masked. The latch clears when any core acknowledges that source. A level-triggered source is pending exactly while its input is 1.
- R10: A source with priority 0 is never delivered.
- R11: A source is delivered only to cores whose route bit it sets, and only while its mask bit is 0. An edge request routed to both cores is consumed by the first acknowledge.
- R12: Writing a 1 in bit 0 of address 0x00 returns all configuration, thresholds, pending latches and in-service records to the R1 state at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_ext | input | 12 | External request lines, sources 0–11 |
| irq_int | input | 4 | On-chip request lines, sources 12–15 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| core_ack | input | 2 | Per-core acknowledge strobe |
| core_eoi | input | 2 | Per-core end-of-interrupt strobe |
| core_irq | output | 2 | Per-core interrupt request |
| core_vec | output | 16 | Per-core acknowledge vector, core c in bits [8c+7:8c] |

## Verification
A corrupted in-service record shows up at the ports within two cycles, in one of two ways. core_irq may fail to rise for a source that should pre-empt, or rise for one that should be blocked. An acknowledge may also return a vector or 0xFF where the other was due. A stale edge latch, or one cleared too early, shows as an interrupt that is repeated or lost after the acknowledge. A wrong route shows as the other core's line toggling. Each scenario therefore drives the state, waits the two-register path from input to core_irq, and then probes it with acknowledge and end-of-interrupt reads.

// File: rtl/nic_pkg.sv
package nic_pkg;
    parameter int unsigned PRIO_W = 4;
    parameter int unsigned VEC_W  = 8;
    parameter int unsigned CORES  = 2;
    parameter int unsigned ADDR_W = 8;
    parameter int unsigned DATA_W = 32;

    localparam int unsigned LEVELS = 1 << PRIO_W;

    typedef struct packed {
        logic [CORES-1:0]  route;
        logic              edge_trig;
        logic              blocked;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } src_cfg_t;

    localparam int unsigned CFG_W = $bits(src_cfg_t);
    localparam logic [VEC_W-1:0] SPURIOUS_VEC = '1;
    localparam src_cfg_t CFG_RESET = '{route: '0, edge_trig: 1'b0, blocked: 1'b1,
                                       prio: '0, vec: '0};
endpackage

// File: rtl/nic_source.sv
module nic_source
    import nic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     soft_rst,
    input  logic     cfg_wr,
    input  src_cfg_t cfg_wdata,
    input  logic     req,
    input  logic     taken,
    output src_cfg_t cfg_q,
    output logic     pending
);
    logic req_d;
    logic edge_pend;
    logic rise;

    assign rise = req & ~req_d;

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cfg_q     <= CFG_RESET;
            req_d     <= 1'b0;
            edge_pend <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q <= cfg_wdata;
            req_d <= req;
            if (rise)       edge_pend <= 1'b1;
            else if (taken) edge_pend <= 1'b0;
        end
    end

    assign pending = cfg_q.edge_trig ? edge_pend : req;

    assert_edge_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise && !soft_rst |=> edge_pend);

    assert_edge_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        taken && !rise && !soft_rst |=> !edge_pend);

    assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cfg_q == CFG_RESET) && !edge_pend);
endmodule

// File: rtl/nic_core.sv
module nic_core
    import nic_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 16,
    parameter int unsigned CORE_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  src_cfg_t          cfg [NUM_SRC],
    input  logic [NUM_SRC-1:0] pending,
    input  logic              tpr_wr,
    input  logic [PRIO_W-1:0] tpr_wdata,
    input  logic              ack,
    input  logic              eoi,
    output logic              irq,
    output logic [VEC_W-1:0]  ack_vec,
    output logic [NUM_SRC-1:0] grant,
    output logic [PRIO_W-1:0] tpr_q
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef enum logic {CORE_QUIET, CORE_RAISED} core_state_e;

    core_state_e       state_q, state_d;
    logic [LEVELS-1:0] isv_q, isv_d;
    logic [PRIO_W-1:0] top_prio;
    logic [PRIO_W-1:0] best_prio;
    logic [IDX_W-1:0]  best_idx;
    logic              found;

    // highest priority currently in service (0 when empty)
    always_comb begin
        top_prio = '0;
        for (int p = 1; p < LEVELS; p++)
            if (isv_q[p]) top_prio = PRIO_W'(p);
    end

    // strict comparisons keep the lowest index on ties
    always_comb begin
        best_prio = '0;
        best_idx  = '0;
        found     = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pending[i] && !cfg[i].blocked && cfg[i].route[CORE_IDX] &&
                cfg[i].prio > tpr_q && cfg[i].prio > top_prio &&
                cfg[i].prio > best_prio) begin
                best_prio = cfg[i].prio;
                best_idx  = IDX_W'(i);
                found     = 1'b1;
            end
        end
    end

    always_comb begin
        ack_vec = found ? cfg[best_idx].vec : SPURIOUS_VEC;
        grant   = '0;
        if (ack && found) grant[best_idx] = 1'b1;
        isv_d = isv_q;
        if (eoi && top_prio != '0) isv_d[top_prio] = 1'b0;
        if (ack && found)          isv_d[best_prio] = 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_QUIET:  if (found)  state_d = CORE_RAISED;
            CORE_RAISED: if (!found) state_d = CORE_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state_q <= CORE_QUIET;
            isv_q   <= '0;
            tpr_q   <= '0;
        end else begin
            state_q <= state_d;
            isv_q   <= isv_d;
            if (tpr_wr) tpr_q <= tpr_wdata;
        end
    end

    always_comb irq = (state_q == CORE_RAISED);

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        found && !soft_rst |=> irq);

    assert_nest_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack && found && !eoi && !soft_rst |=> top_prio > $past(top_prio));

    assert_eoi_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi && !ack && !soft_rst && isv_q != '0
        |=> $countones(isv_q) == $countones($past(isv_q)) - 1);

    assert_spurious_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !found && !eoi && !soft_rst |=> $stable(isv_q));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int unsigned NUM_EXT = 12,
    parameter int unsigned NUM_INT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_EXT-1:0]     irq_ext,
    input  logic [NUM_INT-1:0]     irq_int,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]      cfg_wdata,
    output logic [DATA_W-1:0]      cfg_rdata,
    input  logic [CORES-1:0]       core_ack,
    input  logic [CORES-1:0]       core_eoi,
    output logic [CORES-1:0]       core_irq,
    output logic [CORES*VEC_W-1:0] core_vec
);
    localparam int unsigned NUM_SRC  = NUM_EXT + NUM_INT;
    localparam int unsigned GCR_ADDR = 0;
    localparam int unsigned TPR_BASE = 4;
    localparam int unsigned CFG_BASE = 16;

    logic               soft_rst;
    logic [NUM_SRC-1:0] req_all;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] taken;
    logic [NUM_SRC-1:0] grant [CORES];
    logic [PRIO_W-1:0]  tpr   [CORES];
    src_cfg_t           cfg   [NUM_SRC];
    logic               unused_wdata_bits;

    assign soft_rst          = cfg_we && cfg_addr == ADDR_W'(GCR_ADDR) && cfg_wdata[0];
    assign req_all           = {irq_int, irq_ext};
    assign unused_wdata_bits = ^cfg_wdata[DATA_W-1:CFG_W];

    always_comb begin
        taken = '0;
        for (int c = 0; c < CORES; c++) taken = taken | grant[c];
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        nic_source u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .cfg_wr   (cfg_we && cfg_addr == ADDR_W'(CFG_BASE + i)),
            .cfg_wdata(src_cfg_t'(cfg_wdata[CFG_W-1:0])),
            .req      (req_all[i]),
            .taken    (taken[i]),
            .cfg_q    (cfg[i]),
            .pending  (pending[i])
        );
    end

    for (genvar c = 0; c < CORES; c++) begin : g_core
        nic_core #(.NUM_SRC(NUM_SRC), .CORE_IDX(c)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .cfg      (cfg),
            .pending  (pending),
            .tpr_wr   (cfg_we && cfg_addr == ADDR_W'(TPR_BASE + c)),
            .tpr_wdata(cfg_wdata[PRIO_W-1:0]),
            .ack      (core_ack[c]),
            .eoi      (core_eoi[c]),
            .irq      (core_irq[c]),
            .ack_vec  (core_vec[c*VEC_W +: VEC_W]),
            .grant    (grant[c]),
            .tpr_q    (tpr[c])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (cfg_addr == ADDR_W'(CFG_BASE + i)) cfg_rdata[CFG_W-1:0] = cfg[i];
        for (int c = 0; c < CORES; c++)
            if (cfg_addr == ADDR_W'(TPR_BASE + c)) cfg_rdata[PRIO_W-1:0] = tpr[c];
    end
endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] irq_ext = '0;
    logic [3:0]  irq_int = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  core_ack = '0;
    logic [1:0]  core_eoi = '0;
    logic [1:0]  core_irq;
    logic [15:0] core_vec;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nest_irq_ctrl i_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_ext(irq_ext), .irq_int(irq_int),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .core_ack(core_ack), .core_eoi(core_eoi),
        .core_irq(core_irq), .core_vec(core_vec)
    );

    // fields: src a, prio a, src b, prio b, core0 threshold, expected vector
    localparam logic [27:0] VECTORS [8] = '{
        28'h0515040, 28'h3279047, 28'h32799FF, 28'h3279847,
        28'h20500FF, 28'hBFCF04B, 28'hD14004D, 28'h6464046
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic ack(input int c, output logic [7:0] v);
        @(negedge clk);
        core_ack[c] = 1'b1;
        #1 v = core_vec[c*8 +: 8];
        @(negedge clk);
        core_ack = '0;
    endtask

    task automatic eoi(input int c);
        @(negedge clk);
        core_eoi[c] = 1'b1;
        @(negedge clk);
        core_eoi = '0;
    endtask

    task automatic set_req(input logic [15:0] r);
        @(negedge clk);
        irq_ext = r[11:0];
        irq_int = r[15:12];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  v;
        logic [15:0] r;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset state
        chk("R1 irq", {30'd0, core_irq}, 32'h0);
        rd(8'h10, d); chk("R1 cfg0", d, 32'h1000);
        rd(8'h1F, d); chk("R1 cfg15", d, 32'h1000);
        rd(8'h05, d); chk("R1 tpr1", d, 32'h0);
        ack(1, v); chk("R1 spurious", {24'd0, v}, 32'hFF);

        // R2 field layout and readback, R3 threshold readback
        wr(8'h1A, 32'hFFFF_C3A5);
        rd(8'h1A, d); chk("R2 readback", d, 32'h0000_C3A5);
        wr(8'h05, 32'hFFFF_FFF7);
        rd(8'h05, d); chk("R3 tpr readback", d, 32'h7);

        // table: arbitration, threshold, ties, priority 0 (R3 R5 R10 R4)
        for (int k = 0; k < 8; k++) begin
            logic [27:0] e;
            logic [3:0]  sa, sb;
            e  = VECTORS[k];
            sa = e[27:24]; sb = e[19:16];
            wr(8'h00, 32'h1);
            wr(8'h10 + {4'd0, sa}, 32'h4000 | {20'd0, e[23:20], 8'h00} | (32'h40 + sa));
            wr(8'h10 + {4'd0, sb}, 32'h4000 | {20'd0, e[15:12], 8'h00} | (32'h40 + sb));
            wr(8'h04, {28'd0, e[11:8]});
            r = '0; r[sa] = 1'b1; r[sb] = 1'b1;
            set_req(r);
            step(2);
            chk("R4 R10 table irq", {31'd0, core_irq[0]}, {31'd0, e[7:0] != 8'hFF});
            ack(0, v); chk("R5 R3 table vec", {24'd0, v}, {24'd0, e[7:0]});
            set_req('0);
        end

        // R6 R7 R8 nesting
        wr(8'h00, 32'h1);
        wr(8'h10, 32'h4310);
        wr(8'h11, 32'h4711);
        set_req(16'h0001); step(2);
        ack(0, v); chk("R5 first", {24'd0, v}, 32'h10);
        step(2); chk("R6 equal blocked", {31'd0, core_irq[0]}, 32'h0);
        set_req(16'h0003); step(2);
        chk("R6 preempt irq", {31'd0, core_irq[0]}, 32'h1);
        ack(0, v); chk("R6 preempt vec", {24'd0, v}, 32'h11);
        ack(0, v); chk("R8 nothing eligible", {24'd0, v}, 32'hFF);
        eoi(0); step(2);
        chk("R7 pop top irq", {31'd0, core_irq[0]}, 32'h1);
        ack(0, v); chk("R7 pop top vec", {24'd0, v}, 32'h11);
        eoi(0);
        set_req(16'h0001);
        eoi(0); step(2);
        ack(0, v); chk("R7 lower again", {24'd0, v}, 32'h10);

        // R9 edge latch while masked, clear on ack; level follows input
        wr(8'h00, 32'h1);
        set_req('0);
        wr(8'h12, 32'h7622);
        set_req(16'h0004); set_req('0); step(2);
        chk("R9 masked", {31'd0, core_irq[0]}, 32'h0);
        wr(8'h12, 32'h6622); step(2);
        chk("R9 latched", {31'd0, core_irq[0]}, 32'h1);
        ack(0, v); chk("R9 edge vec", {24'd0, v}, 32'h22);
        eoi(0); step(2);
        chk("R9 cleared irq", {31'd0, core_irq[0]}, 32'h0);
        ack(0, v); chk("R9 cleared vec", {24'd0, v}, 32'hFF);
        wr(8'h14, 32'h4624);
        set_req(16'h0010); step(2);
        chk("R9 level on", {31'd0, core_irq[0]}, 32'h1);
        set_req('0); step(2);
        chk("R9 level off", {31'd0, core_irq[0]}, 32'h0);

        // R11 routing
        wr(8'h00, 32'h1);
        wr(8'h13, 32'h8533);
        set_req(16'h0008); step(2);
        chk("R11 core1 only", {30'd0, core_irq}, 32'h2);
        ack(0, v); chk("R11 core0 none", {24'd0, v}, 32'hFF);
        ack(1, v); chk("R11 core1 vec", {24'd0, v}, 32'h33);
        wr(8'h15, 32'hE955);
        set_req(16'h0028); set_req(16'h0008); step(2);
        chk("R11 both", {30'd0, core_irq}, 32'h3);
        ack(0, v); chk("R11 both vec", {24'd0, v}, 32'h55);
        step(2);
        chk("R11 consumed irq", {30'd0, core_irq}, 32'h0);
        ack(1, v); chk("R11 consumed vec", {24'd0, v}, 32'hFF);

        // R12 global reset
        wr(8'h00, 32'h1);
        set_req(16'h0001);
        wr(8'h10, 32'h4310);
        wr(8'h04, 32'h2); step(2);
        ack(0, v); chk("R12 setup", {24'd0, v}, 32'h10);
        wr(8'h00, 32'h1); step(2);
        rd(8'h10, d); chk("R12 cfg", d, 32'h1000);
        rd(8'h04, d); chk("R12 tpr", d, 32'h0);
        chk("R12 irq", {30'd0, core_irq}, 32'h0);
        ack(0, v); chk("R12 masked", {24'd0, v}, 32'hFF);
        wr(8'h10, 32'h4310); step(2);
        ack(0, v); chk("R12 in-service empty", {24'd0, v}, 32'h10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule